// File: doc/BRIEF.md
# Multi-LFSR Bernoulli Bit Generator

This block emits one pseudo-random bit per enabled clock. The probability that the bit is 1 is set by an 8-bit threshold. Eight short maximal-length shift registers, one of each length from 3 to 10 bits, run side by side. Each one gives a single bit, and together those bits form an 8-bit random word. The word is compared against the threshold, and the result is captured in a one-bit output register. The output is 1 with probability (256 - threshold) / 256.

A decoder or stochastic datapath that needs a cheap biased coin uses the block. The consumer writes the threshold once, optionally loads a 52-bit seed, and raises the enable whenever a fresh bit is wanted. All-zero seed slices are repaired on load, so no register can lock up.

Top module: `bern_bitgen`

## Requirements
- R1: After reset, `bit_o` is 0, the threshold register holds 0xE6, and every shift register holds its all-ones state.
- R2: Bit k of the random word (k = 0..7) is the most significant bit of the shift register of length k+3. The 3-bit register feeds the LSB and the 10-bit register feeds the MSB.
- R3: On a step, each register shifts left by one. The new bit 0 is the XOR of state bits at these positions for each length: 3:{2,1}, 4:{3,2}, 5:{4,2}, 6:{5,4}, 7:{6,5}, 8:{7,5,4,3}, 9:{8,4}, 10:{9,6}.
- R4: On a clock edge with `en_i` high and `seed_load_i` low, `bit_o` becomes 1 when the word present before the edge is greater than or equal to the threshold present before the edge, and 0 otherwise. All registers step on that same edge.
- R5: While `en_i` and `seed_load_i` are both low, no shift register changes and `bit_o` holds its value.
- R6: `seed_load_i` takes priority over `en_i`. On that edge, the register of length L takes `seed_i[off +: L]`, where off = 3k + k(k-1)/2 for k = L-3, and `bit_o` does not change.
- R7: A seed slice that is all zeros loads as the value 1, so no register ever holds zero.
- R8: When `thr_we_i` is high, `thr_i` is written into the threshold register on the next edge, whatever `en_i` is. The write does not change `bit_o` on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Step all registers and capture a new output bit |
| seed_load_i | input | 1 | Load all registers from `seed_i` |
| seed_i | input | 52 | Packed seeds, shortest register at the low end |
| thr_we_i | input | 1 | Write enable for the threshold register |
| thr_i | input | 8 | New threshold value |
| bit_o | output | 1 | Registered Bernoulli bit |

## Verification
A wrong tap, a swapped word bit or a broken zero-seed repair changes the random word. The mismatch reaches `bit_o` on the next enabled edge whenever the threshold falls between the wrong and the right word values. By sweeping thresholds of 0x80, 0x40, 0xE6 and the extremes, the bench exposes errors in the high word bits within a few cycles and errors in the low bits within a few tens of cycles. A hold or priority fault shows up on the very next edge: either `bit_o` moves when it must not, or the following sequence drifts away from the one the bench's model predicts.

// File: rtl/bbg_pkg.sv
package bbg_pkg;
  localparam int unsigned NUM_SRC = 8;
  localparam int unsigned MIN_LEN = 3;
  localparam int unsigned MAX_LEN = MIN_LEN + NUM_SRC - 1;
  localparam int unsigned MASK_W  = 16;

  // bit offset of source k inside the packed seed vector
  function automatic int unsigned seed_off(input int unsigned k);
    return k * MIN_LEN + (k * (k - 1)) / 2;
  endfunction

  localparam int unsigned SEED_W = seed_off(NUM_SRC);

  // feedback tap mask, bit i set means state bit i enters the XOR
  function automatic logic [MASK_W-1:0] tap_mask(input int unsigned len);
    logic [MASK_W-1:0] m;
    case (len)
      3:       m = 16'h0006;
      4:       m = 16'h000C;
      5:       m = 16'h0014;
      6:       m = 16'h0030;
      7:       m = 16'h0060;
      8:       m = 16'h00B8;
      9:       m = 16'h0110;
      10:      m = 16'h0240;
      default: m = 16'h0000;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/bbg_lfsr_cell.sv
module bbg_lfsr_cell #(
  parameter int unsigned LEN     = 3,
  parameter logic [15:0] TAPS    = 16'h0006,
  parameter logic [LEN-1:0] RST_VAL = '1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  input  logic           load_i,
  input  logic [LEN-1:0] seed_i,
  output logic [LEN-1:0] state_o,
  output logic           msb_o
);
  logic [LEN-1:0] st_q, st_d;
  logic [LEN-1:0] seed_fix;
  logic           fb;

  always_comb begin
    fb       = ^(st_q & TAPS[LEN-1:0]);
    seed_fix = (seed_i == '0) ? LEN'(1) : seed_i;
    st_d     = st_q;
    if (load_i)      st_d = seed_fix;
    else if (step_i) st_d = {st_q[LEN-2:0], fb};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= RST_VAL;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
  assign msb_o   = st_q[LEN-1];
endmodule

// File: rtl/bbg_rand_word.sv
module bbg_rand_word
  import bbg_pkg::*;
#(
  parameter logic [SEED_W-1:0] RST_SEED = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [SEED_W-1:0] seed_i,
  output logic [NUM_SRC-1:0] word_o,
  output logic [SEED_W-1:0] state_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int unsigned LEN = MIN_LEN + g;
    localparam int unsigned OFF = seed_off(g);
    bbg_lfsr_cell #(
      .LEN     (LEN),
      .TAPS    (tap_mask(LEN)),
      .RST_VAL (RST_SEED[OFF +: LEN])
    ) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (step_i),
      .load_i  (load_i),
      .seed_i  (seed_i[OFF +: LEN]),
      .state_o (state_o[OFF +: LEN]),
      .msb_o   (word_o[g])
    );
  end
endmodule

// File: rtl/bbg_thresh_unit.sv
module bbg_thresh_unit #(
  parameter int unsigned   W          = 8,
  parameter logic [W-1:0]  DEF_THRESH = 8'hE6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         thr_we_i,
  input  logic [W-1:0] thr_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] thr_o,
  output logic         bit_o
);
  logic [W-1:0] thr_q, thr_d;
  logic         bit_q, bit_d;

  always_comb begin
    thr_d = thr_we_i ? thr_i : thr_q;
    bit_d = cap_i ? (word_i >= thr_q) : bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= DEF_THRESH;
      bit_q <= 1'b0;
    end else begin
      thr_q <= thr_d;
      bit_q <= bit_d;
    end
  end

  assign thr_o = thr_q;
  assign bit_o = bit_q;
endmodule

// File: rtl/bern_bitgen.sv
module bern_bitgen
  import bbg_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] DEF_THRESH = 8'hE6,
  parameter logic [SEED_W-1:0]  RST_SEED   = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              seed_load_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic              thr_we_i,
  input  logic [NUM_SRC-1:0] thr_i,
  output logic              bit_o
);
  logic [NUM_SRC-1:0] word_w;
  logic [NUM_SRC-1:0] thr_w;
  logic [SEED_W-1:0]  state_w;
  logic               step_w;
  logic               cap_w;

  assign step_w = en_i & ~seed_load_i;
  assign cap_w  = step_w;

  bbg_rand_word #(.RST_SEED(RST_SEED)) u_word (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_w),
    .load_i  (seed_load_i),
    .seed_i  (seed_i),
    .word_o  (word_w),
    .state_o (state_w)
  );

  bbg_thresh_unit #(.W(NUM_SRC), .DEF_THRESH(DEF_THRESH)) u_thr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap_w),
    .thr_we_i (thr_we_i),
    .thr_i    (thr_i),
    .word_i   (word_w),
    .thr_o    (thr_w),
    .bit_o    (bit_o)
  );
endmodule

// File: rtl/bbg_checker.sv
module bbg_checker
  import bbg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              seed_load_i,
  input logic [SEED_W-1:0] seed_i,
  input logic              thr_we_i,
  input logic [NUM_SRC-1:0] thr_i,
  input logic [NUM_SRC-1:0] thr_q,
  input logic [NUM_SRC-1:0] word,
  input logic [SEED_W-1:0] state,
  input logic              bit_o
);
  assert_cmp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !seed_load_i) |=> (bit_o == ($past(word) >= $past(thr_q))));

  assert_hold_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !seed_load_i) |=> $stable(bit_o));

  assert_hold_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !seed_load_i) |=> $stable(state));

  assert_load_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> $stable(bit_o));

  assert_thr_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_we_i |=> (thr_q == $past(thr_i)));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    localparam int unsigned LEN = MIN_LEN + g;
    localparam int unsigned OFF = seed_off(g);
    assert_src_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state[OFF +: LEN] != '0);
    assert_word_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word[g] == state[OFF + LEN - 1]);
    assert_seed_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seed_load_i && (seed_i[OFF +: LEN] != '0)) |=> (state[OFF +: LEN] == $past(seed_i[OFF +: LEN])));
  end
endmodule

bind bern_bitgen bbg_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .seed_load_i (seed_load_i),
  .seed_i      (seed_i),
  .thr_we_i    (thr_we_i),
  .thr_i       (thr_i),
  .thr_q       (thr_w),
  .word        (word_w),
  .state       (state_w),
  .bit_o       (bit_o)
);

// File: tb/tb_bern_bitgen.sv
module tb_bern_bitgen;
  localparam int NS = 8;
  localparam int SW = 52;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic          ld;
  logic [SW-1:0] seed;
  logic          we;
  logic [7:0]    thr;
  logic          bit_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [9:0] m [NS];
  logic [7:0] m_thr;
  logic       m_bit;

  always #10 clk = ~clk;

  bern_bitgen dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .seed_load_i(ld), .seed_i(seed),
    .thr_we_i(we), .thr_i(thr), .bit_o(bit_o)
  );

  function automatic logic [9:0] taps(input int k);
    case (k)
      0: return 10'h006; 1: return 10'h00C; 2: return 10'h014; 3: return 10'h030;
      4: return 10'h060; 5: return 10'h0B8; 6: return 10'h110; default: return 10'h240;
    endcase
  endfunction

  function automatic logic [7:0] mword();
    logic [7:0] w;
    for (int k = 0; k < NS; k++) w[k] = m[k][k+2];
    return w;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: bit_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: inputs applied at negedge, bit_o compared at the following negedge
  task automatic cyc(input string req, input logic e, input logic l,
                     input logic [SW-1:0] s, input logic w, input logic [7:0] t);
    en = e; ld = l; seed = s; we = w; thr = t;
    if (l) begin
      for (int k = 0; k < NS; k++) begin
        int off = 3*k + (k*(k-1))/2;
        logic [9:0] v = '0;
        for (int b = 0; b < k+3; b++) v[b] = s[off+b];
        m[k] = (v == 0) ? 10'd1 : v;
      end
    end else if (e) begin
      m_bit = (mword() >= m_thr);
      for (int k = 0; k < NS; k++) begin
        logic fb = ^(m[k] & taps(k));
        m[k] = ((m[k] << 1) | 10'(fb)) & 10'((1 << (k+3)) - 1);
      end
    end
    if (w) m_thr = t;
    @(posedge clk);
    @(negedge clk);
    check(req, bit_o, m_bit);
  endtask

  task automatic run(input string req, input int n);
    for (int i = 0; i < n; i++) cyc(req, 1'b1, 1'b0, '0, 1'b0, 8'h00);
  endtask

  task automatic t_reset();
    for (int k = 0; k < NS; k++) m[k] = 10'((1 << (k+3)) - 1);
    m_thr = 8'hE6; m_bit = 1'b0;
    rst_n = 1'b0; en = 0; ld = 0; seed = '0; we = 0; thr = '0;
    repeat (3) @(negedge clk);
    check("R1", bit_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    run("R1", 60); // default threshold 0xE6 and all-ones start
  endtask

  task automatic t_thresh_sweep();
    cyc("R8", 1'b0, 1'b0, '0, 1'b1, 8'h80);
    run("R2", 50);     // bit equals the 10-bit register MSB
    cyc("R8", 1'b1, 1'b0, '0, 1'b1, 8'h00);
    run("R4", 20);     // threshold 0: always 1
    cyc("R8", 1'b1, 1'b0, '0, 1'b1, 8'hFF);
    run("R4", 300);    // only the all-ones word gives 1
    cyc("R8", 1'b1, 1'b0, '0, 1'b1, 8'h40);
    run("R3", 300);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 8; i++) cyc("R5", 1'b0, 1'b0, '0, 1'b0, 8'h00);
    run("R5", 40);     // sequence resumes exactly where it stopped
    cyc("R8", 1'b0, 1'b0, '0, 1'b1, 8'hA0); // write while idle, bit holds
    run("R8", 40);
  endtask

  task automatic t_seed();
    logic [SW-1:0] s = 52'hA_5C3E_9B71_D2F4;
    cyc("R6", 1'b1, 1'b1, s, 1'b0, 8'h00);  // load wins over enable, bit holds
    run("R6", 120);
    cyc("R6", 1'b0, 1'b1, 52'h3_1F0C_66AD_8E52, 1'b1, 8'h70);
    run("R6", 120);
  endtask

  task automatic t_zero_seed();
    cyc("R7", 1'b1, 1'b1, '0, 1'b1, 8'h90);
    run("R7", 200);
    cyc("R7", 1'b0, 1'b1, 52'hF_FF00_0FFF_0007, 1'b1, 8'h30);
    run("R7", 200);
  endtask

  initial begin
    t_reset();
    t_thresh_sweep();
    t_hold();
    t_seed();
    t_zero_seed();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule